// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback Sequencer

This block is one playback channel of an audio bus master. Software builds a circular table of up to 32 buffer descriptors in memory. Each descriptor is two 32-bit words: the buffer start address, then a length word that also carries two per-buffer flags. Software writes the table address and a last-valid index, then sets the run bit. The sequencer fetches descriptors and sample words over a simple request/acknowledge memory port. It hands the samples one at a time to a consumer that pulls them with a request strobe.

The sequencer steps through the table with a 5-bit index that wraps from 31 to 0. It stops when it completes the buffer at the last-valid index, and picks up again when software moves that index forward. Sticky status bits record buffer completion, completion of the last-valid buffer and consumer underrun. Any enabled status bit raises the interrupt output. The completion bits are cleared by writing a one to them.

Top module: `audio_dma_seq`

## Requirements
- R1: After rst_n the register words read as follows. Word 0x0 reads 0. Word 0x4 reads 0x00030000: indices 0, status halted (bit 0) and current-equals-last (bit 1). Word 0x8 reads 0x00010000: position 0, prefetched index 1, control 0. irq is 0.
- R2: The registers are 32-bit words selected by reg_addr[3:2], with byte enables. Word 0x0 is the table base, and its bits [2:0] always read 0. Word 0x4 holds the current index in [4:0] (read-only) and the last-valid index in [12:8], with status in [31:16]. Word 0x8 holds the position in [15:0], the prefetched index in [20:16] and control in [28:24].
- R3: For the entry at the current index i, the descriptor words are read from base+8*i and base+8*i+4. The sample count is bits [15:0] of the length word. Sample k is read from bufaddr+4*k. Samples appear on out_data in fetch order, one per out_req pulse, in the clock edge that samples out_req.
- R4: The position field counts down the samples of the current buffer still to be fetched. The prefetched index always equals the current index plus 1, modulo 32.
- R5: A buffer completes once its last sample has been fetched. A length of 0 completes it at once. If it is not the last-valid entry, the current index then advances modulo 32, so 31 is followed by 0.
- R6: Completing a buffer whose length-word bit 31 is 1 sets status bit 3. Writing 1 to word 0x4 bit 19 clears it and leaves the other status bits as they are.
- R7: Completing the buffer at the last-valid index sets status bit 2 and the halted bit, and no further descriptor is fetched. When the last-valid index is changed while run is 1, the index advances and streaming resumes.
- R8: While control bit 0 (run) is 0, mem_req stays low and the current index holds. Setting run again continues from the same point.
- R9: An out_req pulse while no fetched sample is held sets status bit 4. out_data then repeats its previous value if the current buffer's length-word bit 30 is 0, and becomes 0 if that bit is 1.
- R10: irq is 1 when any of these pairs is active: status bit 3 with control bit 4, status bit 2 with control bit 2, or status bit 4 with control bit 3.
- R11: Writing control bit 1 clears both indices, the position and all sticky status bits, and stops the channel. Bit 1 always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address (word in [3:2]) |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory acknowledge; mem_rdata is valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| out_req | input | 1 | Consumer sample request strobe |
| out_data | output | 32 | Sample word delivered to the consumer |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the buffer boundaries:
- A zero-length entry must be skipped without emitting a sample. A sequencer that fetched before checking the count would stream stray words.
- The index must wrap from entry 31 to entry 0. A wrong wrap would fetch the descriptor from past the table.
- The channel must stop exactly on the last-valid entry and resume when that index moves. A design that failed here would run past it or stay halted for good.

Underrun is driven under both flag settings, because swapping the repeat and zero policies changes only the value on out_data. The acknowledge clear is checked to leave the neighbouring sticky bit untouched. The pause is checked to keep the memory port silent.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int CNT_W = 16;

  localparam int DESC_IOC_BIT = 31;
  localparam int DESC_BUP_BIT = 30;

  localparam int CT_RUN  = 0;
  localparam int CT_RST  = 1;
  localparam int CT_LVIE = 2;
  localparam int CT_FEIE = 3;
  localparam int CT_IOCE = 4;

  localparam int SB_DCH   = 0;
  localparam int SB_CELV  = 1;
  localparam int SB_LVBC  = 2;
  localparam int SB_BC    = 3;
  localparam int SB_FIFOE = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC0, ST_DESC1, ST_DATA, ST_DONE, ST_HALT
  } seq_state_t;
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [IDX_W-1:0] civ,
  input  logic [CNT_W-1:0] pos,
  input  logic             dch,
  input  logic             evt_bc,
  input  logic             evt_lv,
  input  logic             evt_fe,
  output logic [AW-1:0]    list_base,
  output logic [IDX_W-1:0] lvi,
  output logic             run,
  output logic             chan_rst,
  output logic [4:0]       stat,
  output logic             irq
);
  localparam int PAD = 8 - IDX_W;

  logic [AW-1:0]    base_q, base_n;
  logic [IDX_W-1:0] lvi_q, lvi_n;
  logic [4:0]       ctrl_q, ctrl_n;
  logic             bc_q, bc_n, lvbc_q, lvbc_n, fe_q, fe_n;
  logic             wr0, wr1, wr2;
  logic [IDX_W-1:0] piv;

  assign wr0 = reg_we && (reg_addr[3:2] == 2'd0);
  assign wr1 = reg_we && (reg_addr[3:2] == 2'd1);
  assign wr2 = reg_we && (reg_addr[3:2] == 2'd2);
  assign chan_rst = wr2 && reg_be[3] && reg_wdata[24 + CT_RST];
  assign piv = civ + IDX_W'(1);

  always_comb begin
    base_n = base_q;
    lvi_n  = lvi_q;
    ctrl_n = ctrl_q;
    if (wr0) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) base_n[8*b +: 8] = reg_wdata[8*b +: 8];
    end
    base_n[2:0] = 3'b000;
    if (wr1 && reg_be[1]) lvi_n = reg_wdata[8 +: IDX_W];
    if (wr2 && reg_be[3]) begin
      ctrl_n = reg_wdata[28:24];
      ctrl_n[CT_RST] = 1'b0;
    end
    bc_n   = (bc_q   && !(wr1 && reg_be[2] && reg_wdata[16 + SB_BC]))   || evt_bc;
    lvbc_n = (lvbc_q && !(wr1 && reg_be[2] && reg_wdata[16 + SB_LVBC])) || evt_lv;
    fe_n   = fe_q || evt_fe;
    if (chan_rst) begin
      lvi_n  = '0;
      bc_n   = 1'b0;
      lvbc_n = 1'b0;
      fe_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lvi_q  <= '0;
      ctrl_q <= '0;
      bc_q   <= 1'b0;
      lvbc_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      base_q <= base_n;
      lvi_q  <= lvi_n;
      ctrl_q <= ctrl_n;
      bc_q   <= bc_n;
      lvbc_q <= lvbc_n;
      fe_q   <= fe_n;
    end
  end

  assign stat = {fe_q, bc_q, lvbc_q, (civ == lvi_q), dch};

  always_comb begin
    unique case (reg_addr[3:2])
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = {11'd0, stat, {PAD{1'b0}}, lvi_q, {PAD{1'b0}}, civ};
      2'd2:    reg_rdata = {3'd0, ctrl_q, {PAD{1'b0}}, piv, pos};
      default: reg_rdata = '0;
    endcase
  end

  assign list_base = base_q;
  assign lvi       = lvi_q;
  assign run       = ctrl_q[CT_RUN];
  assign irq = (bc_q && ctrl_q[CT_IOCE]) || (lvbc_q && ctrl_q[CT_LVIE]) ||
               (fe_q && ctrl_q[CT_FEIE]);
endmodule

// File: rtl/adma_seq.sv
module adma_seq
  import adma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             chan_rst,
  input  logic [AW-1:0]    list_base,
  input  logic [IDX_W-1:0] lvi,
  input  logic             hold_full,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             push,
  output logic [DW-1:0]    push_data,
  output logic [IDX_W-1:0] civ,
  output logic [CNT_W-1:0] pos,
  output logic             dch,
  output logic             cur_bup,
  output logic             evt_bc,
  output logic             evt_lv
);
  seq_state_t       st_q, st_n;
  logic [IDX_W-1:0] civ_q, civ_n;
  logic [CNT_W-1:0] pos_q, pos_n, offs_q, offs_n;
  logic [AW-1:0]    bbase_q, bbase_n, desc_addr;
  logic             ioc_q, ioc_n, bup_q, bup_n, take;

  assign desc_addr = list_base + {{(AW-IDX_W-3){1'b0}}, civ_q, 3'b000};
  assign mem_req = run && ((st_q == ST_DESC0) || (st_q == ST_DESC1) ||
                   ((st_q == ST_DATA) && (pos_q != '0) && !hold_full));
  assign take = mem_req && mem_ack;

  always_comb begin
    unique case (st_q)
      ST_DESC0: mem_addr = desc_addr;
      ST_DESC1: mem_addr = desc_addr + AW'(4);
      default:  mem_addr = bbase_q + {{(AW-CNT_W-2){1'b0}}, offs_q, 2'b00};
    endcase
  end

  always_comb begin
    st_n    = st_q;
    civ_n   = civ_q;
    pos_n   = pos_q;
    offs_n  = offs_q;
    bbase_n = bbase_q;
    ioc_n   = ioc_q;
    bup_n   = bup_q;
    push    = 1'b0;
    evt_bc  = 1'b0;
    evt_lv  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (run) st_n = ST_DESC0;
      ST_DESC0: if (take) begin
        bbase_n = mem_rdata[AW-1:0];
        st_n    = ST_DESC1;
      end
      ST_DESC1: if (take) begin
        pos_n  = mem_rdata[CNT_W-1:0];
        ioc_n  = mem_rdata[DESC_IOC_BIT];
        bup_n  = mem_rdata[DESC_BUP_BIT];
        offs_n = '0;
        st_n   = ST_DATA;
      end
      ST_DATA: begin
        if (pos_q == '0) st_n = ST_DONE;
        else if (take) begin
          push   = 1'b1;
          pos_n  = pos_q - CNT_W'(1);
          offs_n = offs_q + CNT_W'(1);
        end
      end
      ST_DONE: begin
        evt_bc = ioc_q;
        if (civ_q == lvi) begin
          evt_lv = 1'b1;
          st_n   = ST_HALT;
        end else begin
          civ_n = civ_q + IDX_W'(1);
          st_n  = ST_DESC0;
        end
      end
      ST_HALT: if (run && (lvi != civ_q)) begin
        civ_n = civ_q + IDX_W'(1);
        st_n  = ST_DESC0;
      end
      default: st_n = ST_IDLE;
    endcase
    if (chan_rst) begin
      st_n   = ST_IDLE;
      civ_n  = '0;
      pos_n  = '0;
      offs_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      civ_q   <= '0;
      pos_q   <= '0;
      offs_q  <= '0;
      bbase_q <= '0;
      ioc_q   <= 1'b0;
      bup_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      civ_q   <= civ_n;
      pos_q   <= pos_n;
      offs_q  <= offs_n;
      bbase_q <= bbase_n;
      ioc_q   <= ioc_n;
      bup_q   <= bup_n;
    end
  end

  assign push_data = mem_rdata;
  assign civ       = civ_q;
  assign pos       = pos_q;
  assign dch       = (st_q == ST_IDLE) || (st_q == ST_HALT);
  assign cur_bup   = bup_q;
endmodule

// File: rtl/adma_outport.sv
module adma_outport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          bup,
  input  logic          out_req,
  output logic [DW-1:0] out_data,
  output logic          hold_full,
  output logic          evt_fe
);
  logic [DW-1:0] hold_q, hold_n, out_q, out_n;
  logic          full_q, full_n;

  always_comb begin
    hold_n = hold_q;
    full_n = full_q;
    out_n  = out_q;
    evt_fe = 1'b0;
    if (out_req) begin
      if (full_q) begin
        out_n  = hold_q;
        full_n = 1'b0;
      end else begin
        evt_fe = 1'b1;
        out_n  = bup ? '0 : out_q;
      end
    end
    if (push && !full_q) begin
      hold_n = push_data;
      full_n = 1'b1;
    end
    if (chan_rst) full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      out_q  <= '0;
    end else begin
      hold_q <= hold_n;
      full_q <= full_n;
      out_q  <= out_n;
    end
  end

  assign out_data  = out_q;
  assign hold_full = full_q;
endmodule

// File: rtl/audio_dma_seq.sv
module audio_dma_seq
  import adma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          out_req,
  output logic [DW-1:0] out_data,
  output logic          irq
);
  logic [AW-1:0]    list_base;
  logic [IDX_W-1:0] lvi, civ;
  logic [CNT_W-1:0] pos;
  logic [4:0]       stat;
  logic [DW-1:0]    push_data;
  logic run, chan_rst, dch, evt_bc, evt_lv, evt_fe, push, hold_full, cur_bup;

  adma_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .civ(civ), .pos(pos), .dch(dch), .evt_bc(evt_bc), .evt_lv(evt_lv),
    .evt_fe(evt_fe), .list_base(list_base), .lvi(lvi), .run(run),
    .chan_rst(chan_rst), .stat(stat), .irq(irq)
  );

  adma_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .chan_rst(chan_rst),
    .list_base(list_base), .lvi(lvi), .hold_full(hold_full),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .push(push), .push_data(push_data), .civ(civ),
    .pos(pos), .dch(dch), .cur_bup(cur_bup), .evt_bc(evt_bc),
    .evt_lv(evt_lv)
  );

  adma_outport #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .push(push),
    .push_data(push_data), .bup(cur_bup), .out_req(out_req),
    .out_data(out_data), .hold_full(hold_full), .evt_fe(evt_fe)
  );
endmodule

// File: rtl/adma_chk.sv
module adma_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] civ,
  input logic [IDX_W-1:0] lvi,
  input logic [15:0]      pos,
  input logic [4:0]       stat,
  input logic             run,
  input logic             chan_rst,
  input logic             mem_req,
  input logic             irq,
  input logic [3:0]       reg_addr,
  input logic [31:0]      reg_rdata
);
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (civ != $past(civ)) |-> (civ == IDX_W'($past(civ) + IDX_W'(1)) || civ == '0)); // R5

  AST_PIV_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:2] == 2'd2) |-> (reg_rdata[16 +: IDX_W] == IDX_W'(civ + IDX_W'(1)))); // R4

  AST_STOP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ((civ != $past(civ)) && !$past(chan_rst)) |-> ($past(civ) != $past(lvi))); // R7

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat[2] || stat[3] || stat[4])); // R10

  AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_rst) |-> (civ == '0 && lvi == '0 && pos == '0 && stat[4:2] == 3'b000)); // R11
endmodule

bind audio_dma_seq adma_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .civ(civ), .lvi(lvi), .pos(pos), .stat(stat),
  .run(run), .chan_rst(chan_rst), .mem_req(mem_req), .irq(irq),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_audio_dma_seq.sv
`timescale 1ns/1ps
module tb_audio_dma_seq;
  localparam logic [31:0] LBASE = 32'h0000_1000;
  localparam int GAP = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr, reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack, ack_en;
  logic [31:0] mem_addr, mem_rdata;
  logic        out_req;
  logic [31:0] out_data;
  logic        irq;

  logic [31:0] desc_base [32];
  logic [31:0] desc_len  [32];

  int n_chk = 0, n_fail = 0, req_in_pause = 0;
  bit done = 0, paused = 0;
  logic [31:0] rd, last;

  always #2 clk = ~clk;

  audio_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .out_req(out_req), .out_data(out_data), .irq(irq)
  );

  function automatic logic [31:0] sample_val(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h1357_9BDF;
  endfunction

  always_comb begin
    mem_ack = mem_req & ack_en;
    if (mem_addr >= LBASE && mem_addr < LBASE + 32'd256)
      mem_rdata = mem_addr[2] ? desc_len[mem_addr[7:3]] : desc_base[mem_addr[7:3]];
    else
      mem_rdata = sample_val(mem_addr);
  end

  always @(negedge clk) ack_en <= (($urandom % 4) != 0);
  always @(posedge clk) if (paused && mem_req) req_in_pause++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pull(output logic [31:0] d);
    repeat (GAP) @(negedge clk);
    out_req = 1'b1;
    @(negedge clk);
    out_req = 1'b0;
    d = out_data;
  endtask

  task automatic stream(input int i, input string req);
    logic [31:0] d;
    for (int k = 0; k < int'(desc_len[i][15:0]); k++) begin
      pull(d);
      chk(req, d, sample_val(desc_base[i] + 32'(4 * k)));
      last = d;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 4'h0; reg_be = 4'h0;
    reg_wdata = '0; out_req = 1'b0;
    for (int i = 0; i < 32; i++) begin
      desc_base[i] = 32'h0002_0000 + 32'(i) * 32'h100;
      desc_len[i]  = 32'd0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdreg(4'h0, rd); chk("R1 base", rd, 32'h0);
    rdreg(4'h4, rd); chk("R1 word4", rd, 32'h0003_0000);
    rdreg(4'h8, rd); chk("R1 word8", rd, 32'h0001_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 base alignment
    wr(4'h0, 4'hF, LBASE | 32'h7);
    rdreg(4'h0, rd); chk("R2 base low bits", rd, LBASE);

    // directed list: 3 samples IOC, zero length, 2 samples IOC+zero-fill, 4 samples repeat
    desc_len[0] = 32'h8000_0003;
    desc_len[1] = 32'h0000_0000;
    desc_len[2] = 32'hC000_0002;
    desc_len[3] = 32'h0000_0004;
    wr(4'h4, 4'b0010, 32'h0000_0200);
    wr(4'h8, 4'b1000, 32'h1100_0000);
    stream(0, "R3 buf0");
    stream(2, "R3 R5 zero-length skip buf2");
    repeat (200) @(negedge clk);
    rdreg(4'h4, rd); chk("R7 R6 halt at last valid", rd, 32'h000F_0202);
    rdreg(4'h8, rd); chk("R4 pos/piv at halt", rd, 32'h1103_0000);
    chk("R10 irq from completion", {31'd0, irq}, 32'd1);

    // R9 underrun with zero-fill policy
    pull(rd); chk("R9 zero fill", rd, 32'h0);
    rdreg(4'h4, rd); chk("R9 fifo error flag", rd, 32'h001F_0202);

    // R6 acknowledge completion only
    wr(4'h4, 4'b0100, 32'h0008_0000);
    rdreg(4'h4, rd); chk("R6 w1c", rd, 32'h0017_0202);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R8 pause, then move last valid
    wr(4'h8, 4'b1000, 32'h1800_0000);
    chk("R10 irq from fifo error", {31'd0, irq}, 32'd1);
    paused = 1;
    wr(4'h4, 4'b0010, 32'h0000_0300);
    repeat (40) @(negedge clk);
    paused = 0;
    chk("R8 no request while paused", 32'(req_in_pause), 32'd0);
    rdreg(4'h4, rd); chk("R8 index holds", {27'd0, rd[4:0]}, 32'd2);
    wr(4'h8, 4'b1000, 32'h1900_0000);
    stream(3, "R7 R8 resume buf3");
    repeat (200) @(negedge clk);
    rdreg(4'h4, rd); chk("R7 second halt", rd, 32'h0017_0303);
    pull(rd); chk("R9 repeat last", rd, last);

    // R11 channel reset
    wr(4'h8, 4'b1000, 32'h0200_0000);
    rdreg(4'h4, rd); chk("R11 word4", rd, 32'h0003_0000);
    rdreg(4'h8, rd); chk("R11 word8", rd, 32'h0001_0000);
    chk("R11 irq", {31'd0, irq}, 32'd0);

    // random ring covering the 31 -> 0 wrap
    for (int i = 0; i < 32; i++) begin
      desc_base[i] = 32'h0004_0000 + 32'(i) * 32'h200 + 32'(($urandom % 16) * 4);
      desc_len[i]  = {($urandom % 2) == 1, ($urandom % 2) == 1, 14'd0, 16'($urandom % 4)};
    end
    wr(4'h4, 4'b0010, 32'h0000_1F00);
    wr(4'h8, 4'b1000, 32'h0100_0000);
    for (int i = 0; i < 32; i++) stream(i, "R3 random ring");
    repeat (400) @(negedge clk);
    rdreg(4'h4, rd); chk("R7 halt at 31", {27'd0, rd[4:0]}, 32'd31);
    chk("R7 halted bit", {31'd0, rd[16]}, 32'd1);
    wr(4'h4, 4'b0010, 32'h0000_0100);
    stream(0, "R5 wrap buf0");
    stream(1, "R5 wrap buf1");
    repeat (400) @(negedge clk);
    rdreg(4'h4, rd); chk("R5 index after wrap", {27'd0, rd[4:0]}, 32'd1);
    rdreg(4'h8, rd); chk("R4 piv after wrap", {27'd0, rd[20:16]}, 32'd2);

    done = 1;
    summary();
    $finish;
  end
endmodule